// File: doc/BRIEF.md
# Sized Data Memory Port

This block is the data-side memory of a single-cycle processor core. It holds a small word-organised RAM split into four byte lanes. It serves loads and stores of byte, halfword and word size. A two-bit size code and a sign-extend flag tell it how to size each access, so the core does not build byte enables or shift load data itself. A load is answered combinationally in the cycle it is presented. A store takes effect on the next rising clock edge and touches only the byte lanes that the size code and the low address bits select.

The core drives an address, store data, a request-valid strobe, separate read and write strobes, the size code and the extension flag. It gets back the sized load data, a response flag and an always-ready flag. Because the memory never stalls, the core may ignore both flags. A sub-word access may start at any offset that keeps it inside one word. An access that would cross a word boundary is not supported.

Top module: `dmem_sized_port`

## Requirements
- R1: The size code on `maskmode` selects the access width: 0 selects a byte, 1 a halfword and 2 a word. Code 3 behaves exactly like code 2.
- R2: A byte load returns the byte in lane `address[1:0]`. Lanes are little-endian, so lane k is bits 8k+7..8k of the word. When `sext` is 1 the byte is sign extended to 32 bits. When `sext` is 0 bits 31..8 are zero.
- R3: A halfword load returns lanes 3..2 when `address[1]` is 1 and lanes 1..0 when it is 0. `address[0]` is ignored. The value is sign extended when `sext` is 1 and zero extended when it is 0.
- R4: A word load returns all four lanes. It ignores `address[1:0]` and `sext`.
- R5: A byte store writes `writedata[7:0]` into lane `address[1:0]` on the rising clock edge. The other three bytes of the word keep their values.
- R6: A halfword store writes `writedata[15:0]` into lanes 3..2 when `address[1]` is 1 and into lanes 1..0 otherwise. The other two bytes keep their values.
- R7: A word store writes all 32 bits of `writedata`.
- R8: Memory changes only at an edge where both `valid` and `memwrite` are 1. Any other combination leaves every byte unchanged.
- R9: When `valid` and `memread` are both 1, `readdata` carries the sized load in the same cycle and `good` is 1. Otherwise `good` is 0 and `readdata` is 0.
- R10: `ready` is 1 in every cycle after reset.
- R11: While `rst_n` is 0, every byte of memory is cleared to zero.
- R12: The word index is `address[IDX_W+1:2]`, where IDX_W = log2(DEPTH_WORDS). Higher address bits are ignored, so addresses that differ by DEPTH_WORDS*4 refer to the same word.
- R13: A load and a store presented in the same cycle make the load return the contents from before the store. The store takes effect at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the memory |
| address | input | ADDR_W | Byte address of the access |
| writedata | input | 32 | Store data, aligned to bit 0 |
| valid | input | 1 | Request strobe |
| memread | input | 1 | Load request |
| memwrite | input | 1 | Store request |
| maskmode | input | 2 | Access size code: 0 byte, 1 halfword, 2 or 3 word |
| sext | input | 1 | Sign-extend sub-word loads when 1 |
| readdata | output | 32 | Sized and extended load data |
| good | output | 1 | Load response present this cycle |
| ready | output | 1 | Always-accepting flag |

## Verification
The bound checker watches every cycle. It checks that the upper bits of each sub-word load are either zero or copies of the sign bit, as the extension flag demands. It checks that an idle port drives zero and a silent `good`, that `ready` stays high, and that repeated word loads of one address with no store in between stay stable. Lane selection and byte merging on stores need a model of memory contents, so only the bench's scenarios can show them. The same holds for aliasing of high address bits, clearing on reset, and the read-before-write order within one cycle. The bench keeps a byte-array reference model for this purpose.

// File: rtl/dmem_port_pkg.sv
package dmem_port_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;
endpackage

// File: rtl/dmem_lane_ctrl.sv
module dmem_lane_ctrl
    import dmem_port_pkg::*;
(
    input  size_e              size,
    input  logic [OFF_W-1:0]   offset,
    input  logic [WORD_W-1:0]  store_data,
    output logic [LANES-1:0]   lane_sel,
    output logic [WORD_W-1:0]  lane_data
);
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                lane_sel  = LANES'(1) << offset;
                lane_data = {LANES{store_data[LANE_W-1:0]}};
            end
            SZ_HALF: begin
                lane_sel  = offset[1] ? 4'b1100 : 4'b0011;
                lane_data = {2{store_data[2*LANE_W-1:0]}};
            end
            SZ_WORD, SZ_WIDE: begin
                lane_sel  = '1;
                lane_data = store_data;
            end
        endcase
    end
endmodule

// File: rtl/dmem_load_fmt.sv
module dmem_load_fmt
    import dmem_port_pkg::*;
(
    input  size_e              size,
    input  logic [OFF_W-1:0]   offset,
    input  logic               sign_ext,
    input  logic [WORD_W-1:0]  word_in,
    output logic [WORD_W-1:0]  load_out
);
    logic [LANE_W-1:0]   pick_b;
    logic [2*LANE_W-1:0] pick_h;

    always_comb begin
        pick_b = word_in[offset*LANE_W +: LANE_W];
        pick_h = offset[1] ? word_in[WORD_W-1 -: 2*LANE_W] : word_in[2*LANE_W-1:0];
        unique case (size)
            SZ_BYTE: load_out = {{(WORD_W-LANE_W){sign_ext & pick_b[LANE_W-1]}}, pick_b};
            SZ_HALF: load_out = {{(WORD_W-2*LANE_W){sign_ext & pick_h[2*LANE_W-1]}}, pick_h};
            SZ_WORD, SZ_WIDE: load_out = word_in;
        endcase
    end
endmodule

// File: rtl/dmem_lane_ram.sv
module dmem_lane_ram
    import dmem_port_pkg::*;
#(
    parameter int DEPTH_WORDS = 64,
    localparam int IDX_W = $clog2(DEPTH_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx,
    input  logic [LANES-1:0]   wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH_WORDS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH_WORDS; i++) cells[i] <= '0;
            end else if (wr_en[g]) begin
                cells[idx] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[idx];
    end
endmodule

// File: rtl/dmem_sized_port.sv
module dmem_sized_port
    import dmem_port_pkg::*;
#(
    parameter int DEPTH_WORDS = 64,
    parameter int ADDR_W      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  address,
    input  logic [31:0]        writedata,
    input  logic               valid,
    input  logic               memread,
    input  logic               memwrite,
    input  logic [1:0]         maskmode,
    input  logic               sext,
    output logic [31:0]        readdata,
    output logic               good,
    output logic               ready
);
    localparam int IDX_W = $clog2(DEPTH_WORDS);

    size_e              size;
    logic [OFF_W-1:0]   offset;
    logic [IDX_W-1:0]   word_idx;
    logic [LANES-1:0]   lane_sel;
    logic [LANES-1:0]   lane_we;
    logic [WORD_W-1:0]  lane_data;
    logic [WORD_W-1:0]  raw_word;
    logic [WORD_W-1:0]  sized_word;
    logic               rd_req;
    logic               wr_req;
    logic               unused_addr_hi;

    assign size     = size_e'(maskmode);
    assign offset   = address[OFF_W-1:0];
    assign word_idx = address[IDX_W+OFF_W-1:OFF_W];
    assign unused_addr_hi = ^address[ADDR_W-1:IDX_W+OFF_W];

    assign rd_req  = valid & memread;
    assign wr_req  = valid & memwrite;
    assign lane_we = lane_sel & {LANES{wr_req}};

    dmem_lane_ctrl i_lane_ctrl (
        .size       (size),
        .offset     (offset),
        .store_data (writedata),
        .lane_sel   (lane_sel),
        .lane_data  (lane_data)
    );

    dmem_lane_ram #(.DEPTH_WORDS(DEPTH_WORDS)) i_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (word_idx),
        .wr_en   (lane_we),
        .wr_data (lane_data),
        .rd_data (raw_word)
    );

    dmem_load_fmt i_load_fmt (
        .size     (size),
        .offset   (offset),
        .sign_ext (sext),
        .word_in  (raw_word),
        .load_out (sized_word)
    );

    assign readdata = rd_req ? sized_word : '0;
    assign good     = rd_req;
    assign ready    = 1'b1;
endmodule

// File: rtl/dmem_port_checker.sv
module dmem_port_checker #(
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  address,
    input logic               valid,
    input logic               memread,
    input logic               memwrite,
    input logic [1:0]         maskmode,
    input logic               sext,
    input logic [31:0]        readdata,
    input logic               good,
    input logic               ready
);
    assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready == 1'b1);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && memread) |-> (readdata == 32'd0 && !good));

    assert_good_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(good) |-> (valid && memread));

    assert_byte_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && memread && maskmode == 2'd0 && !sext) |-> readdata[31:8] == 24'd0);

    assert_byte_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && memread && maskmode == 2'd0 && sext) |-> readdata[31:8] == {24{readdata[7]}});

    assert_half_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && memread && maskmode == 2'd1 && !sext) |-> readdata[31:16] == 16'd0);

    assert_half_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && memread && maskmode == 2'd1 && sext) |-> readdata[31:16] == {16{readdata[15]}});

    // R8: with no store, a repeated word load of the same address keeps its value
    assert_no_store_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(valid && memread && !memwrite && maskmode == 2'd2)
         && valid && memread && !memwrite && maskmode == 2'd2
         && address == $past(address)) |-> readdata == $past(readdata));
endmodule

bind dmem_sized_port dmem_port_checker #(.ADDR_W(ADDR_W)) i_port_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .address  (address),
    .valid    (valid),
    .memread  (memread),
    .memwrite (memwrite),
    .maskmode (maskmode),
    .sext     (sext),
    .readdata (readdata),
    .good     (good),
    .ready    (ready)
);

// File: tb/test_dmem_sized_port.sv
module test_dmem_sized_port;
    localparam int DEPTH = 64;
    localparam int IDX_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] address = '0;
    logic [31:0] writedata = '0;
    logic        valid = 1'b0;
    logic        memread = 1'b0;
    logic        memwrite = 1'b0;
    logic [1:0]  maskmode = 2'd2;
    logic        sext = 1'b0;
    logic [31:0] readdata;
    logic        good;
    logic        ready;

    logic [7:0]  ref_mem [DEPTH*4];
    int          n_checks = 0;
    int          n_fails = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    dmem_sized_port #(.DEPTH_WORDS(DEPTH), .ADDR_W(32)) i_dmem_sized_port (
        .clk(clk), .rst_n(rst_n), .address(address), .writedata(writedata),
        .valid(valid), .memread(memread), .memwrite(memwrite),
        .maskmode(maskmode), .sext(sext), .readdata(readdata),
        .good(good), .ready(ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_load(input logic [31:0] a, input logic [1:0] m, input logic sx);
        int base = int'(a[IDX_W+1:2]) * 4;
        logic [7:0]  b;
        logic [15:0] h;
        int hb;
        if (m == 2'd0) begin
            b = ref_mem[base + int'(a[1:0])];
            return sx ? {{24{b[7]}}, b} : {24'd0, b};
        end else if (m == 2'd1) begin
            hb = a[1] ? 2 : 0;
            h = {ref_mem[base+hb+1], ref_mem[base+hb]};
            return sx ? {{16{h[15]}}, h} : {16'd0, h};
        end
        return {ref_mem[base+3], ref_mem[base+2], ref_mem[base+1], ref_mem[base]};
    endfunction

    task automatic ref_store(input logic [31:0] a, input logic [31:0] d, input logic [1:0] m);
        int base = int'(a[IDX_W+1:2]) * 4;
        if (m == 2'd0) ref_mem[base + int'(a[1:0])] = d[7:0];
        else if (m == 2'd1) begin
            ref_mem[base + (a[1] ? 2 : 0)]     = d[7:0];
            ref_mem[base + (a[1] ? 2 : 0) + 1] = d[15:8];
        end else for (int k = 0; k < 4; k++) ref_mem[base+k] = d[8*k +: 8];
    endtask

    task automatic go_idle();
        @(negedge clk);
        valid = 1'b0; memread = 1'b0; memwrite = 1'b0;
    endtask

    task automatic store(input string req, input logic [31:0] a, input logic [31:0] d,
                         input logic [1:0] m, input logic v = 1'b1, input logic mw = 1'b1);
        @(negedge clk);
        address = a; writedata = d; maskmode = m;
        valid = v; memwrite = mw; memread = 1'b0;
        @(posedge clk);
        if (v && mw) ref_store(a, d, m);
        go_idle();
        if (req.len() == 0) return;
    endtask

    task automatic load(input string req, input logic [31:0] a, input logic [1:0] m, input logic sx);
        @(negedge clk);
        address = a; maskmode = m; sext = sx;
        valid = 1'b1; memread = 1'b1; memwrite = 1'b0;
        #1;
        chk(req, readdata, ref_load(a, m, sx));
        chk({req, " good"}, {31'd0, good}, 32'd1);
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < DEPTH*4; i++) ref_mem[i] = 8'd0;
        @(negedge clk);
        #1;
        chk("R9 idle readdata", readdata, 32'd0);
        chk("R9 idle good", {31'd0, good}, 32'd0);
        chk("R10 ready", {31'd0, ready}, 32'd1);
        load("R11 cleared word 0", 32'h0, 2'd2, 1'b0);
        load("R11 cleared word 63", 32'hFC, 2'd2, 1'b0);
        go_idle();
    endtask

    task automatic t_reset_clears();
        store("", 32'h40, 32'hDEADBEEF, 2'd2);
        load("R7 word before reset", 32'h40, 2'd2, 1'b0);
        go_idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH*4; i++) ref_mem[i] = 8'd0;
        load("R11 cleared after reset pulse", 32'h40, 2'd2, 1'b0);
        go_idle();
    endtask

    task automatic t_words();
        store("", 32'h10, 32'h89AB_CDEF, 2'd2);
        store("", 32'h17, 32'h1234_5678, 2'd2);
        load("R7 R4 word readback", 32'h10, 2'd2, 1'b0);
        load("R4 word ignores low bits and sext", 32'h13, 2'd2, 1'b1);
        load("R4 word store ignores low bits", 32'h14, 2'd2, 1'b0);
        store("", 32'h20, 32'hCAFE_F00D, 2'd3);
        load("R1 code 3 acts as word", 32'h20, 2'd3, 1'b1);
        go_idle();
    endtask

    task automatic t_bytes();
        store("", 32'h30, 32'h1111_1111, 2'd2);
        store("", 32'h32, 32'hFFFF_FF80, 2'd0);
        load("R5 byte merge keeps neighbours", 32'h30, 2'd2, 1'b0);
        for (int k = 0; k < 4; k++) begin
            store("", 32'h38 + k, 32'hA0 + 32'(k) * 32'h11, 2'd0);
        end
        for (int k = 0; k < 4; k++) begin
            load("R2 byte sext", 32'h38 + k, 2'd0, 1'b1);
            load("R2 byte zext", 32'h38 + k, 2'd0, 1'b0);
        end
        load("R5 four byte lanes assembled", 32'h38, 2'd2, 1'b0);
        go_idle();
    endtask

    task automatic t_halves();
        store("", 32'h50, 32'h0000_0000, 2'd2);
        store("", 32'h53, 32'hABCD_9876, 2'd1);
        store("", 32'h51, 32'h5555_7FEE, 2'd1);
        load("R6 halfword merge", 32'h50, 2'd2, 1'b0);
        load("R3 upper half sext", 32'h52, 2'd1, 1'b1);
        load("R3 upper half zext, bit0 ignored", 32'h53, 2'd1, 1'b0);
        load("R3 lower half sext", 32'h50, 2'd1, 1'b1);
        go_idle();
    endtask

    task automatic t_write_gating();
        store("", 32'h60, 32'h0F0F_0F0F, 2'd2);
        store("", 32'h60, 32'hFFFF_FFFF, 2'd2, 1'b0, 1'b1);
        load("R8 memwrite without valid ignored", 32'h60, 2'd2, 1'b0);
        store("", 32'h60, 32'hFFFF_FFFF, 2'd2, 1'b1, 1'b0);
        load("R8 valid without memwrite ignored", 32'h60, 2'd2, 1'b0);
        @(negedge clk);
        address = 32'h60; maskmode = 2'd2; valid = 1'b0; memread = 1'b1;
        #1;
        chk("R9 memread without valid gives zero", readdata, 32'd0);
        chk("R9 memread without valid no good", {31'd0, good}, 32'd0);
        go_idle();
    endtask

    task automatic t_alias();
        store("", 32'h24, 32'h7654_3210, 2'd2);
        load("R12 high bits alias", 32'h24 + DEPTH*4, 2'd2, 1'b0);
        load("R12 far alias", 32'h8000_0024, 2'd2, 1'b0);
        go_idle();
    endtask

    task automatic t_read_during_write();
        logic [31:0] old;
        store("", 32'h70, 32'h1357_9BDF, 2'd2);
        old = ref_load(32'h70, 2'd2, 1'b0);
        @(negedge clk);
        address = 32'h70; writedata = 32'h2468_ACE0; maskmode = 2'd2;
        valid = 1'b1; memread = 1'b1; memwrite = 1'b1;
        #1;
        chk("R13 load sees old contents", readdata, old);
        @(posedge clk);
        ref_store(32'h70, 32'h2468_ACE0, 2'd2);
        load("R13 store lands at edge", 32'h70, 2'd2, 1'b0);
        go_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_reset_clears();
        t_words();
        t_bytes();
        t_halves();
        t_write_gating();
        t_alias();
        t_read_during_write();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule